// File: doc/BRIEF.md
# Shared Counter with Per-Core Compare Timers

This block keeps one free-running up-counter shared by every core of a cluster and gives each core a compare timer built on it. The counter is up to 64 bits wide. Software reads it through a low and a high 32-bit register. The two halves are not captured together, so a reader fetches the high half, then the low half, then the high half again, and retries if the two high values differ. A configuration word reports the counter width as 32 plus four times a small field. Each core owns a compare value, written as independent low and high halves. When the counter reaches that value, the core's timer pending bit is set. The core's timer line is raised when the pending bit is set, the mask bit is set and the timer is marked routable.

Register accesses arrive on a single write/read port that carries the index of the requesting core. Each core reaches its own registers through a local window. Through a second, redirected window it reaches the registers of whichever core it has named in its own selector register, so one core can program another core's compare. Mask bits are changed only through a set register and a clear register, each taking a one-hot local-interrupt bit. The counter may be loaded only while it is stopped.

Top module: `shared_cmp_timer`

## Requirements
- R1: After reset the counter is zero and stopped, every mask and pending bit is 0, every timer is routable (control bit 0 = 1), every compare value is all ones, every selector is 0, and `timer_irq` is all zero.
- R2: While the run bit (bit 0 of the control word at address 0x01) is 1, the counter adds one on every clock and wraps from 2^CNT_W-1 to 0, carrying from the low half into the high half. While the run bit is 0 the counter holds.
- R3: Address 0x02 reads counter bits 31:0 and address 0x03 reads bits CNT_W-1:32, zero-extended. Writes to these two addresses load the matching half only while the counter is stopped, and are ignored while it runs.
- R4: The configuration word at address 0x00 reads (CNT_W-32)/4 in bits 3:0 and NUM_CORES-1 in bits 11:8, which is 0x304 with the defaults.
- R5: Core offset 0 holds compare bits 31:0 and offset 1 holds compare bits CNT_W-1:32. Each is written independently and reads back, with the high half zero-extended.
- R6: A core's pending bit (bit 0 at offset 2) is set at the clock edge where the counter equals the full compare value, and it stays set until it is cleared.
- R7: Any write to either compare half clears that core's pending bit. In a cycle where a match and a compare write coincide, the write wins.
- R8: Writing offset 4 with bit 0 set sets the mask bit (read at offset 3, bit 0). Writing offset 5 with bit 0 set clears it. Other data bits in these writes have no effect.
- R9: A core's `timer_irq` is 1 exactly when its pending bit, its mask bit and its routable flag (offset 6, bit 0) are all 1. Clearing the routable flag does not clear the pending bit.
- R10: Offset 7 of a core holds its selector. Addresses 0x20+offset reach the registers of the core named in the requester's selector.
- R11: Addresses 0x10+offset reach the requester's own registers. An access changes only the targeted core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the current access |
| reg_addr | input | 6 | Word address: 0x00-0x03 shared, 0x10-0x17 local window, 0x20-0x27 redirected window |
| reg_core | input | CORE_W | Index of the requesting core |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register (combinational) |
| timer_irq | output | NUM_CORES | Per-core timer interrupt line |

## Verification
Two things can fall on the same edge: a counter match that sets a core's pending bit, and a write to that core's compare that clears it. The bench stops the counter on a value equal to the compare, so a match is presented on every edge. It then rewrites the compare high half with the same value. Directly after that write edge the pending bit must read 0, which shows the write took priority. One edge later it must read 1 again, because the unchanged match sets it. A second overlap, a load of the counter while it is running, is judged by checking that the counter still advanced by exactly one.

// File: rtl/sct_pkg.sv
package sct_pkg;

    typedef enum logic [1:0] {
        WIN_SH   = 2'd0,
        WIN_LOC  = 2'd1,
        WIN_OTH  = 2'd2,
        WIN_NONE = 2'd3
    } win_e;

    typedef enum logic [1:0] {
        SH_CFG    = 2'd0,
        SH_CTRL   = 2'd1,
        SH_CNT_LO = 2'd2,
        SH_CNT_HI = 2'd3
    } sh_off_e;

    typedef enum logic [2:0] {
        CO_CMP_LO = 3'd0,
        CO_CMP_HI = 3'd1,
        CO_PEND   = 3'd2,
        CO_MASK   = 3'd3,
        CO_MSET   = 3'd4,
        CO_MCLR   = 3'd5,
        CO_CTL    = 3'd6,
        CO_OSEL   = 3'd7
    } core_off_e;

    // Local interrupt number of the timer inside pend/mask/set/clear words
    localparam int TMR_BIT = 0;
    // Run bit inside the shared control word
    localparam int RUN_BIT = 0;

    function automatic logic [31:0] cfg_word(input int cnt_w, input int ncores);
        logic [31:0] w;
        w       = '0;
        w[3:0]  = 4'((cnt_w - 32) / 4);
        w[11:8] = 4'(ncores - 1);
        return w;
    endfunction

endpackage

// File: rtl/sct_counter.sv
module sct_counter
    import sct_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sh_we,
    input  sh_off_e          sh_off,
    input  logic [31:0]      wdata,
    output logic             run,
    output logic [CNT_W-1:0] cnt
);
    localparam int HI_W = CNT_W - 32;

    logic load_lo, load_hi;
    assign load_lo = sh_we && (sh_off == SH_CNT_LO);
    assign load_hi = sh_we && (sh_off == SH_CNT_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else begin
            if (sh_we && (sh_off == SH_CTRL))
                run <= wdata[RUN_BIT];
            if (run)
                cnt <= cnt + CNT_W'(1);
            else if (load_lo)
                cnt[31:0] <= wdata;
            else if (load_hi)
                cnt[CNT_W-1:32] <= wdata[HI_W-1:0];
        end
    end

    // R2: running counter steps by exactly one, loads or not
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        run |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

    // R2: stopped counter without load holds
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !load_lo && !load_hi) |=> $stable(cnt));

    // R3: low-half load while stopped lands
    a_r3_load_lo: assert property (@(posedge clk) disable iff (rst)
        (!run && load_lo) |=> (cnt[31:0] == $past(wdata)));

endmodule

// File: rtl/sct_decode.sv
module sct_decode
    import sct_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             reg_we,
    input  logic [5:0]                       reg_addr,
    input  logic [CORE_W-1:0]                reg_core,
    input  logic [NUM_CORES-1:0][CORE_W-1:0] osel_all,
    output logic                             sh_acc,
    output logic                             sh_we,
    output sh_off_e                          sh_off,
    output logic                             core_acc,
    output core_off_e                        core_off,
    output logic [CORE_W-1:0]                tgt,
    output logic [NUM_CORES-1:0]             hit_we
);
    win_e win;
    logic in_range;

    assign win      = win_e'(reg_addr[5:4]);
    assign sh_off   = sh_off_e'(reg_addr[1:0]);
    assign core_off = core_off_e'(reg_addr[2:0]);
    assign sh_acc   = (win == WIN_SH) && (reg_addr[3:2] == 2'b00);
    assign sh_we    = reg_we && sh_acc;

    always_comb begin
        if (win == WIN_OTH)
            tgt = osel_all[reg_core];
        else
            tgt = reg_core;
    end

    assign in_range = int'(tgt) < NUM_CORES;
    assign core_acc = ((win == WIN_LOC) || (win == WIN_OTH)) && !reg_addr[3] && in_range;

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_hit
        assign hit_we[i] = reg_we && core_acc && (tgt == CORE_W'(i));
    end

    // R11: a write reaches at most one core
    a_r11_one_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_we));

    // R10/R11: shared and per-core accesses never overlap
    a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(sh_acc && core_acc));

endmodule

// File: rtl/sct_core.sv
module sct_core
    import sct_pkg::*;
#(
    parameter int CNT_W  = 48,
    parameter int CORE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              hit_we,
    input  core_off_e         off,
    input  logic [31:0]       wdata,
    output logic [31:0]       rd_word,
    output logic [CORE_W-1:0] osel,
    output logic              irq
);
    localparam int HI_W = CNT_W - 32;

    typedef struct packed {
        logic [CNT_W-1:0]  cmp;
        logic              pend;
        logic              mask;
        logic              rtbl;
        logic [CORE_W-1:0] osel;
    } core_st_t;

    core_st_t st;
    logic match, cmp_wr, mset, mclr;

    assign match  = (cnt == st.cmp);
    assign cmp_wr = hit_we && ((off == CO_CMP_LO) || (off == CO_CMP_HI));
    assign mset   = hit_we && (off == CO_MSET) && wdata[TMR_BIT];
    assign mclr   = hit_we && (off == CO_MCLR) && wdata[TMR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            st.cmp  <= '1;
            st.pend <= 1'b0;
            st.mask <= 1'b0;
            st.rtbl <= 1'b1;
            st.osel <= '0;
        end else begin
            if (cmp_wr)
                st.pend <= 1'b0;
            else if (match)
                st.pend <= 1'b1;
            if (mset)
                st.mask <= 1'b1;
            else if (mclr)
                st.mask <= 1'b0;
            if (hit_we) begin
                case (off)
                    CO_CMP_LO: st.cmp[31:0]       <= wdata;
                    CO_CMP_HI: st.cmp[CNT_W-1:32] <= wdata[HI_W-1:0];
                    CO_CTL:    st.rtbl            <= wdata[TMR_BIT];
                    CO_OSEL:   st.osel            <= wdata[CORE_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_word = '0;
        case (off)
            CO_CMP_LO: rd_word = st.cmp[31:0];
            CO_CMP_HI: rd_word = 32'(st.cmp[CNT_W-1:32]);
            CO_PEND:   rd_word[TMR_BIT] = st.pend;
            CO_MASK:   rd_word[TMR_BIT] = st.mask;
            CO_CTL:    rd_word[TMR_BIT] = st.rtbl;
            CO_OSEL:   rd_word = 32'(st.osel);
            default:   rd_word = '0;
        endcase
    end

    assign osel = st.osel;
    assign irq  = st.pend && st.mask && st.rtbl;

    // R7: a compare write leaves pending clear, even against a match
    a_r7_write_clears: assert property (@(posedge clk) disable iff (rst)
        cmp_wr |=> !st.pend);

    // R6: a match without a compare write sets pending
    a_r6_match_sets: assert property (@(posedge clk) disable iff (rst)
        (match && !cmp_wr) |=> st.pend);

    // R6: pending is sticky until a compare write
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (st.pend && !cmp_wr) |=> st.pend);

    // R8: set and clear strobes act on the mask
    a_r8_set: assert property (@(posedge clk) disable iff (rst)
        mset |=> st.mask);
    a_r8_clr: assert property (@(posedge clk) disable iff (rst)
        (mclr && !mset) |=> !st.mask);

endmodule

// File: rtl/shared_cmp_timer.sv
module shared_cmp_timer
    import sct_pkg::*;
#(
    parameter  int NUM_CORES = 4,
    parameter  int CNT_W     = 48,
    localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [5:0]           reg_addr,
    input  logic [CORE_W-1:0]    reg_core,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic [NUM_CORES-1:0] timer_irq
);
    localparam logic [31:0] CFG = cfg_word(CNT_W, NUM_CORES);

    logic                             run;
    logic [CNT_W-1:0]                 cnt;
    logic                             sh_acc, sh_we, core_acc;
    sh_off_e                          sh_off;
    core_off_e                        core_off;
    logic [CORE_W-1:0]                tgt;
    logic [NUM_CORES-1:0]             hit_we;
    logic [NUM_CORES-1:0][CORE_W-1:0] osel_all;
    logic [NUM_CORES-1:0][31:0]       core_rd;

    sct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .sh_we  (sh_we),
        .sh_off (sh_off),
        .wdata  (reg_wdata),
        .run    (run),
        .cnt    (cnt)
    );

    sct_decode #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_core (reg_core),
        .osel_all (osel_all),
        .sh_acc   (sh_acc),
        .sh_we    (sh_we),
        .sh_off   (sh_off),
        .core_acc (core_acc),
        .core_off (core_off),
        .tgt      (tgt),
        .hit_we   (hit_we)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        sct_core #(.CNT_W(CNT_W), .CORE_W(CORE_W)) u_core (
            .clk     (clk),
            .rst     (rst),
            .cnt     (cnt),
            .hit_we  (hit_we[c]),
            .off     (core_off),
            .wdata   (reg_wdata),
            .rd_word (core_rd[c]),
            .osel    (osel_all[c]),
            .irq     (timer_irq[c])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (core_acc) begin
            reg_rdata = core_rd[tgt];
        end else if (sh_acc) begin
            case (sh_off)
                SH_CFG:    reg_rdata = CFG;
                SH_CTRL:   reg_rdata[RUN_BIT] = run;
                SH_CNT_LO: reg_rdata = cnt[31:0];
                SH_CNT_HI: reg_rdata = 32'(cnt[CNT_W-1:32]);
                default:   reg_rdata = '0;
            endcase
        end
    end

    // R4: the configuration word never changes
    a_r4_cfg_const: assert property (@(posedge clk) disable iff (rst)
        (sh_acc && sh_off == SH_CFG) |-> (reg_rdata[3:0] == 4'((CNT_W - 32) / 4)));

endmodule

// File: tb/shared_cmp_timer_tb.sv
`timescale 1ns/1ps
module shared_cmp_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [1:0]  reg_core = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  timer_irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    shared_cmp_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_core  (reg_core),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .timer_irq (timer_irq)
    );

    typedef struct packed {
        logic        rd;
        logic [1:0]  core;
        logic [5:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } step_t;

    localparam int NSTEP = 26;
    localparam step_t TBL [NSTEP] = '{
        '{1'b1, 2'd0, 6'h00, 32'h0000_0304, 4'd4},  // R4 config word
        '{1'b0, 2'd1, 6'h10, 32'h0000_1234, 4'd5},  // R5 compare low
        '{1'b1, 2'd1, 6'h10, 32'h0000_1234, 4'd5},
        '{1'b0, 2'd1, 6'h11, 32'hFFFF_ABCD, 4'd5},  // R5 compare high
        '{1'b1, 2'd1, 6'h11, 32'h0000_ABCD, 4'd5},
        '{1'b1, 2'd1, 6'h10, 32'h0000_1234, 4'd5},  // R5 halves independent
        '{1'b1, 2'd0, 6'h10, 32'hFFFF_FFFF, 4'd11}, // R11 other core untouched
        '{1'b0, 2'd0, 6'h17, 32'h0000_0002, 4'd10}, // R10 selector
        '{1'b1, 2'd0, 6'h17, 32'h0000_0002, 4'd10},
        '{1'b0, 2'd0, 6'h20, 32'h0000_0055, 4'd10}, // R10 redirected write
        '{1'b1, 2'd2, 6'h10, 32'h0000_0055, 4'd10},
        '{1'b1, 2'd0, 6'h10, 32'hFFFF_FFFF, 4'd10},
        '{1'b1, 2'd0, 6'h20, 32'h0000_0055, 4'd10},
        '{1'b0, 2'd3, 6'h14, 32'hFFFF_FFFE, 4'd8},  // R8 set, wrong bit
        '{1'b1, 2'd3, 6'h13, 32'h0000_0000, 4'd8},
        '{1'b0, 2'd3, 6'h14, 32'h0000_0001, 4'd8},
        '{1'b1, 2'd3, 6'h13, 32'h0000_0001, 4'd8},
        '{1'b0, 2'd3, 6'h15, 32'hFFFF_FFFE, 4'd8},  // R8 clear, wrong bit
        '{1'b1, 2'd3, 6'h13, 32'h0000_0001, 4'd8},
        '{1'b0, 2'd3, 6'h15, 32'h0000_0001, 4'd8},
        '{1'b1, 2'd3, 6'h13, 32'h0000_0000, 4'd8},
        '{1'b0, 2'd0, 6'h02, 32'hDEAD_BEEF, 4'd3},  // R3 load low while stopped
        '{1'b1, 2'd0, 6'h02, 32'hDEAD_BEEF, 4'd3},
        '{1'b0, 2'd0, 6'h03, 32'h0001_2345, 4'd3},  // R3 load high
        '{1'b1, 2'd0, 6'h03, 32'h0000_2345, 4'd3},
        '{1'b1, 2'd0, 6'h16, 32'h0000_0001, 4'd9}   // R9 routable after reset
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] core, input logic [5:0] addr, input logic [31:0] data);
        reg_core  = core;
        reg_addr  = addr;
        reg_wdata = data;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] core, input logic [5:0] addr, output logic [31:0] data);
        reg_core = core;
        reg_addr = addr;
        #1;
        data = reg_rdata;
    endtask

    task automatic rdchk(input string tag, input logic [1:0] core, input logic [5:0] addr,
                         input logic [31:0] exp);
        logic [31:0] v;
        rd(core, addr, v);
        chk(tag, v, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", 32'(timer_irq), 32'h0);
        rdchk("R1 cnt lo", 2'd0, 6'h02, 32'h0);
        rdchk("R1 cnt hi", 2'd0, 6'h03, 32'h0);
        rdchk("R1 run", 2'd0, 6'h01, 32'h0);
        rdchk("R1 pend", 2'd2, 6'h12, 32'h0);
        rdchk("R1 mask", 2'd2, 6'h13, 32'h0);
        rdchk("R1 cmp", 2'd3, 6'h11, 32'h0000_FFFF);
        rdchk("R1 sel", 2'd1, 6'h17, 32'h0);

        for (int i = 0; i < NSTEP; i++) begin
            if (TBL[i].rd) begin
                logic [31:0] v;
                rd(TBL[i].core, TBL[i].addr, v);
                n_chk++;
                if (v !== TBL[i].data) begin
                    n_fail++;
                    $display("FAIL R%0d step %0d: got %h expected %h", TBL[i].req, i, v, TBL[i].data);
                end
            end else begin
                wr(TBL[i].core, TBL[i].addr, TBL[i].data);
            end
        end

        // R6/R9 match on core 1
        wr(2'd0, 6'h02, 32'h40);
        wr(2'd0, 6'h03, 32'h0);
        wr(2'd1, 6'h11, 32'h0);
        wr(2'd1, 6'h10, 32'h45);
        wr(2'd1, 6'h14, 32'h1);
        rdchk("R7 pend after cmp write", 2'd1, 6'h12, 32'h0);
        chk("R9 irq idle", 32'(timer_irq), 32'h0);
        wr(2'd0, 6'h01, 32'h1);
        rdchk("R2 start value", 2'd0, 6'h02, 32'h40);
        repeat (5) @(negedge clk);
        rdchk("R2 counted", 2'd0, 6'h02, 32'h45);
        rdchk("R6 not yet", 2'd1, 6'h12, 32'h0);
        @(negedge clk);
        rdchk("R6 set on match", 2'd1, 6'h12, 32'h1);
        chk("R9 irq raised", 32'(timer_irq), 32'h2);
        repeat (3) @(negedge clk);
        rdchk("R6 sticky", 2'd1, 6'h12, 32'h1);
        rdchk("R2 step", 2'd0, 6'h02, 32'h49);

        // R3 load ignored while running
        wr(2'd0, 6'h02, 32'h0);
        rdchk("R3 load ignored", 2'd0, 6'h02, 32'h4A);
        wr(2'd0, 6'h01, 32'h0);
        repeat (3) @(negedge clk);
        rdchk("R2 hold", 2'd0, 6'h02, 32'h4B);

        // R9 gating
        wr(2'd1, 6'h16, 32'h0);
        chk("R9 not routable", 32'(timer_irq), 32'h0);
        rdchk("R9 pend kept", 2'd1, 6'h12, 32'h1);
        wr(2'd1, 6'h16, 32'h1);
        chk("R9 routable again", 32'(timer_irq), 32'h2);
        wr(2'd1, 6'h15, 32'h1);
        chk("R9 masked", 32'(timer_irq), 32'h0);
        wr(2'd1, 6'h14, 32'h1);
        chk("R9 unmasked", 32'(timer_irq), 32'h2);

        // R7 clear by compare write
        wr(2'd1, 6'h11, 32'h0);
        rdchk("R7 cleared", 2'd1, 6'h12, 32'h0);
        chk("R7 irq low", 32'(timer_irq), 32'h0);

        // R10 redirected compare write, then R7 collision with match
        wr(2'd0, 6'h17, 32'h1);
        wr(2'd0, 6'h20, 32'h4B);
        rdchk("R10 redirected cmp", 2'd1, 6'h10, 32'h4B);
        rdchk("R7 write edge", 2'd1, 6'h12, 32'h0);
        @(negedge clk);
        rdchk("R6 stopped match", 2'd1, 6'h12, 32'h1);
        wr(2'd1, 6'h11, 32'h0);
        rdchk("R7 write beats match", 2'd1, 6'h12, 32'h0);
        @(negedge clk);
        rdchk("R6 match resumes", 2'd1, 6'h12, 32'h1);

        // R2 carry into high half
        wr(2'd0, 6'h03, 32'h0);
        wr(2'd0, 6'h02, 32'hFFFF_FFFF);
        wr(2'd0, 6'h01, 32'h1);
        rdchk("R2 pre carry", 2'd0, 6'h02, 32'hFFFF_FFFF);
        @(negedge clk);
        rdchk("R2 carry lo", 2'd0, 6'h02, 32'h0);
        rdchk("R2 carry hi", 2'd0, 6'h03, 32'h1);
        wr(2'd0, 6'h01, 32'h0);

        // R2 full wrap
        wr(2'd0, 6'h03, 32'hFFFF);
        wr(2'd0, 6'h02, 32'hFFFF_FFFF);
        wr(2'd0, 6'h01, 32'h1);
        rdchk("R2 pre wrap", 2'd0, 6'h03, 32'hFFFF);
        @(negedge clk);
        rdchk("R2 wrap hi", 2'd0, 6'h03, 32'h0);
        rdchk("R2 wrap lo", 2'd0, 6'h02, 32'h0);
        wr(2'd0, 6'h01, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule